// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a 16-bit processor core and takes over the core's memory port and its PC, status-word and stack-pointer (R6) write paths while an interrupt is taken or a return from interrupt is carried out. At an instruction boundary, the block compares a pending request's 3-bit level with the level held in the running status word. If the request is accepted, the block saves the status word and the PC on the stack. It then reads the handler address from a vector table page and installs a privileged status word that carries the new level. A return request restores the PC and the status word from the stack. If the core is in user mode, a return request is refused and reported as a privilege fault.

Each sequence spends one memory access per state. The memory is single-cycle: read data is valid in the cycle the address is presented. While a sequence runs, `busy` stalls the core. In the cycle the PC, status-word and stack-pointer writes commit, `done` pulses once. The status word keeps the user flag in bit 15 (1 = user mode, 0 = privileged) and the running level in bits 10:8.

Top module: `irq_seq`

## Requirements
- R1: A request whose level is lower than status bits 10:8 is refused. After a refusal, `busy` stays low and no memory access or register write follows.
- R2: A request whose level is equal to or greater than status bits 10:8 is accepted at the boundary.
- R3: Requests are sampled only in a cycle where `at_boundary` is high. A request in any other cycle has no effect.
- R4: After acceptance, the first busy cycle writes the old status word to address SP-1. The second busy cycle writes the old PC to address SP-2.
- R5: The third busy cycle reads the handler address from 0x0100 | vector and writes it to the PC.
- R6: In that same cycle, the status word is set to 0 except for bits 10:8, which take the request level. The stack pointer becomes SP-2.
- R7: A privileged return reads the PC from SP in its first busy cycle. In its second busy cycle it reads the status word from SP+1, commits the PC and status word, and sets the stack pointer to SP+2.
- R8: A return while status bit 15 is 1 raises `priv_fault` in that cycle. It causes no memory access, no register write and no busy cycle.
- R9: `busy` is high in every cycle of a sequence, and each of those cycles makes exactly one memory access. `done` is a single-cycle pulse that coincides with the PC, status-word and stack-pointer writes.
- R10: When a return request and an interrupt request arrive in the same idle cycle, the return is executed and the interrupt is not taken.
- R11: After reset, `busy`, `done`, `priv_fault`, `mem_req` and all register write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| at_boundary | input | 1 | High between the end of one instruction and the next fetch |
| irq_req | input | 1 | Interrupt request pending |
| irq_lvl | input | 3 | Requested priority level |
| irq_vec | input | 8 | Interrupt vector number |
| rti_req | input | 1 | Return-from-interrupt execute strobe from the decoder |
| psr_in | input | 16 | Current status word |
| pc_in | input | 16 | Current PC (address of next instruction) |
| sp_in | input | 16 | Current R6 value |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| pc_we | output | 1 | PC write enable |
| pc_wdata | output | 16 | New PC |
| psr_we | output | 1 | Status word write enable |
| psr_wdata | output | 16 | New status word |
| sp_we | output | 1 | R6 write enable |
| sp_wdata | output | 16 | New R6 value |
| busy | output | 1 | Sequence in progress; the core stalls |
| done | output | 1 | Final register update commits this cycle |
| priv_fault | output | 1 | Return attempted in user mode |

## Verification
The assertions assume that the core does not change `psr_in`, `pc_in` or `sp_in` on the strength of its own instructions while `busy` is high. They also assume that `rti_req` appears only as a one-cycle strobe and never during a running sequence. The stimulus follows these rules: it drives each request for exactly one cycle, one cycle after a clock edge, and it holds the core-state inputs still until the sequence has drained. The stimulus also includes a stack pointer of 0x0001, so that the push addresses wrap through 0x0000 to 0xFFFF.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_E_PSR,
    S_E_PC,
    S_E_VEC,
    S_R_PC,
    S_R_PSR
  } seq_state_t;
endpackage

// File: rtl/irq_seq_accept.sv
module irq_seq_accept #(
  parameter int LVL_W = 3
) (
  input  logic             idle,
  input  logic             at_boundary,
  input  logic             irq_req,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [LVL_W-1:0] run_lvl,
  input  logic             rti_req,
  input  logic             user_mode,
  output logic             take_irq,
  output logic             take_rti,
  output logic             fault
);
  logic outranked;

  always_comb begin
    outranked = (run_lvl > irq_lvl);
    take_rti  = idle && rti_req && !user_mode;
    fault     = idle && rti_req && user_mode;
    take_irq  = idle && !rti_req && at_boundary && irq_req && !outranked;
  end
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int DW       = 16,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int LVL_LSB  = 8,
  parameter logic [DW-VEC_W-1:0] VEC_PAGE = 'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_irq,
  input  logic             take_rti,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [DW-1:0]    psr_in,
  input  logic [DW-1:0]    pc_in,
  input  logic [DW-1:0]    sp_in,
  input  logic [DW-1:0]    mem_rdata,
  output logic             idle,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             pc_we,
  output logic [DW-1:0]    pc_wdata,
  output logic             psr_we,
  output logic [DW-1:0]    psr_wdata,
  output logic             sp_we,
  output logic [DW-1:0]    sp_wdata,
  output logic             busy,
  output logic             done
);
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] TWO = DW'(2);

  seq_state_t       state_q, state_d;
  logic [DW-1:0]    sp_q, pc_q, psr_q, ret_pc_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic             snap_en, ret_pc_en;
  logic [DW-1:0]    entry_psr;

  always_comb begin
    entry_psr = '0;
    entry_psr[LVL_LSB +: LVL_W] = lvl_q;
  end

  always_comb begin
    state_d   = state_q;
    snap_en   = 1'b0;
    ret_pc_en = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    pc_we     = 1'b0;
    pc_wdata  = '0;
    psr_we    = 1'b0;
    psr_wdata = '0;
    sp_we     = 1'b0;
    sp_wdata  = '0;
    done      = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (take_rti) begin
          snap_en = 1'b1;
          state_d = S_R_PC;
        end else if (take_irq) begin
          snap_en = 1'b1;
          state_d = S_E_PSR;
        end
      end
      S_E_PSR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - ONE;
        mem_wdata = psr_q;
        state_d   = S_E_PC;
      end
      S_E_PC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - TWO;
        mem_wdata = pc_q;
        state_d   = S_E_VEC;
      end
      S_E_VEC: begin
        mem_req   = 1'b1;
        mem_addr  = {VEC_PAGE, vec_q};
        pc_we     = 1'b1;
        pc_wdata  = mem_rdata;
        psr_we    = 1'b1;
        psr_wdata = entry_psr;
        sp_we     = 1'b1;
        sp_wdata  = sp_q - TWO;
        done      = 1'b1;
        state_d   = S_IDLE;
      end
      S_R_PC: begin
        mem_req   = 1'b1;
        mem_addr  = sp_q;
        ret_pc_en = 1'b1;
        state_d   = S_R_PSR;
      end
      S_R_PSR: begin
        mem_req   = 1'b1;
        mem_addr  = sp_q + ONE;
        pc_we     = 1'b1;
        pc_wdata  = ret_pc_q;
        psr_we    = 1'b1;
        psr_wdata = mem_rdata;
        sp_we     = 1'b1;
        sp_wdata  = sp_q + TWO;
        done      = 1'b1;
        state_d   = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      pc_q  <= '0;
      psr_q <= '0;
      lvl_q <= '0;
      vec_q <= '0;
    end else if (snap_en) begin
      sp_q  <= sp_in;
      pc_q  <= pc_in;
      psr_q <= psr_in;
      lvl_q <= irq_lvl;
      vec_q <= irq_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_pc_q <= '0;
    end else if (ret_pc_en) begin
      ret_pc_q <= mem_rdata;
    end
  end

  assign idle = (state_q == S_IDLE);
  assign busy = !idle;

  // R9: each busy cycle is exactly one memory access
  a_r9_busy_access: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mem_req);
  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: the three register writes commit together with done
  a_r9_commit_together: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_we && psr_we && sp_we && busy));
  // R2: an accepted request starts a busy sequence in the next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq || take_rti) |=> (busy && mem_req));
  // R4: the status-word push is followed by the PC push one below it
  a_r4_push_order: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_we && $rose(busy)) |=> (mem_we && mem_addr == $past(mem_addr) - ONE));
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int DW      = 16,
  parameter int LVL_W   = 3,
  parameter int VEC_W   = 8,
  parameter int LVL_LSB = 8,
  parameter int USR_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             at_boundary,
  input  logic             irq_req,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             rti_req,
  input  logic [DW-1:0]    psr_in,
  input  logic [DW-1:0]    pc_in,
  input  logic [DW-1:0]    sp_in,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             pc_we,
  output logic [DW-1:0]    pc_wdata,
  output logic             psr_we,
  output logic [DW-1:0]    psr_wdata,
  output logic             sp_we,
  output logic [DW-1:0]    sp_wdata,
  output logic             busy,
  output logic             done,
  output logic             priv_fault
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       idle, take_irq, take_rti, fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  irq_seq_accept #(.LVL_W(LVL_W)) u_accept (
    .idle        (idle),
    .at_boundary (at_boundary),
    .irq_req     (irq_req),
    .irq_lvl     (irq_lvl),
    .run_lvl     (psr_in[LVL_LSB +: LVL_W]),
    .rti_req     (rti_req),
    .user_mode   (psr_in[USR_BIT]),
    .take_irq    (take_irq),
    .take_rti    (take_rti),
    .fault       (fault)
  );

  irq_seq_ctrl #(
    .DW(DW), .LVL_W(LVL_W), .VEC_W(VEC_W), .LVL_LSB(LVL_LSB)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .take_irq  (take_irq),
    .take_rti  (take_rti),
    .irq_lvl   (irq_lvl),
    .irq_vec   (irq_vec),
    .psr_in    (psr_in),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .mem_rdata (mem_rdata),
    .idle      (idle),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_we     (pc_we),
    .pc_wdata  (pc_wdata),
    .psr_we    (psr_we),
    .psr_wdata (psr_wdata),
    .sp_we     (sp_we),
    .sp_wdata  (sp_wdata),
    .busy      (busy),
    .done      (done)
  );

  assign priv_fault = fault && rst_sync_n;

  // R8: a refused return touches nothing and does not start a sequence
  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    priv_fault |-> (!mem_req && !pc_we && !psr_we && !sp_we) ##1 !busy);
  // R1: an outranked request leaves the block idle
  a_r1_reject_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && at_boundary && irq_req && !rti_req &&
     psr_in[LVL_LSB +: LVL_W] > irq_lvl) |=> !busy);
  // R3: no boundary, no start
  a_r3_boundary_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !at_boundary && !rti_req) |=> !busy);
endmodule

// File: tb/irq_seq_test.sv
module irq_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        at_boundary, irq_req, rti_req;
  logic [2:0]  irq_lvl;
  logic [7:0]  irq_vec;
  logic [15:0] psr_in, pc_in, sp_in;
  logic        mem_req, mem_we, pc_we, psr_we, sp_we, busy, done, priv_fault;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_wdata, psr_wdata, sp_wdata;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  irq_seq uut (.*);

  // single-cycle memory model, 9 address bits
  logic [15:0] mem [0:511];
  assign mem_rdata = mem[mem_addr[8:0]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[8:0]] <= mem_wdata;

  // kinds: 1 mem write, 2 mem read, 3 pc, 4 psr, 5 sp
  typedef struct {
    int          kind;
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } item_t;
  item_t exp_q[$];

  task automatic push(int kind, logic [15:0] addr, logic [15:0] data, string tag);
    item_t it;
    it.kind = kind; it.addr = addr; it.data = data; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic observe(int kind, logic [15:0] addr, logic [15:0] data);
    item_t it;
    if (exp_q.size() == 0) begin
      check(1'b0, "unexpected event", 16'(kind), 16'h0);
      return;
    end
    it = exp_q.pop_front();
    check(it.kind == kind, it.tag, 16'(kind), 16'(it.kind));
    if (it.kind == kind) begin
      if (kind <= 2) check(addr == it.addr, it.tag, addr, it.addr);
      if (kind != 2) check(data == it.data, it.tag, data, it.data);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we)  observe(1, mem_addr, mem_wdata);
      if (mem_req && !mem_we) observe(2, mem_addr, 16'h0);
      if (pc_we)  observe(3, 16'h0, pc_wdata);
      if (psr_we) observe(4, 16'h0, psr_wdata);
      if (sp_we)  observe(5, 16'h0, sp_wdata);
    end
  end

  task automatic idle_inputs();
    at_boundary = 1'b0; irq_req = 1'b0; rti_req = 1'b0;
    irq_lvl = '0; irq_vec = '0;
  endtask

  task automatic expect_busy(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(busy == 1'b1, tag, 16'(busy), 16'h1);
      check(done == (i == n-1), tag, 16'(done), 16'(i == n-1));
    end
    @(negedge clk);
    check(busy == 1'b0, tag, 16'(busy), 16'h0);
    check(exp_q.size() == 0, {tag, " drained"}, 16'(exp_q.size()), 16'h0);
  endtask

  task automatic do_irq(logic [15:0] psr, logic [15:0] pc, logic [15:0] sp,
                        logic [2:0] lvl, logic [7:0] vec, logic [15:0] handler);
    logic [15:0] npsr;
    npsr = 16'h0; npsr[10:8] = lvl;
    mem[{1'b1, vec}] = handler;
    push(1, sp - 16'd1, psr, "R4 psr push");
    push(1, sp - 16'd2, pc, "R4 pc push");
    push(2, {8'h01, vec}, 16'h0, "R5 vector read");
    push(3, 16'h0, handler, "R5 handler pc");
    push(4, 16'h0, npsr, "R6 entry psr");
    push(5, 16'h0, sp - 16'd2, "R6 entry sp");
    @(posedge clk); #1;
    psr_in = psr; pc_in = pc; sp_in = sp;
    at_boundary = 1'b1; irq_req = 1'b1; irq_lvl = lvl; irq_vec = vec;
    @(posedge clk); #1;
    idle_inputs();
    expect_busy(3, "R9 entry busy/done");
  endtask

  task automatic do_rti(logic [15:0] sp, logic [15:0] rpc, logic [15:0] rpsr, bit with_irq);
    mem[sp[8:0]] = rpc;
    mem[9'(sp + 16'd1)] = rpsr;
    push(2, sp, 16'h0, "R7 pc pop");
    push(2, sp + 16'd1, 16'h0, "R7 psr pop");
    push(3, 16'h0, rpc, "R7 return pc");
    push(4, 16'h0, rpsr, "R7 return psr");
    push(5, 16'h0, sp + 16'd2, "R7 return sp");
    @(posedge clk); #1;
    psr_in = 16'h0200; sp_in = sp; pc_in = 16'h0042;
    rti_req = 1'b1;
    if (with_irq) begin
      at_boundary = 1'b1; irq_req = 1'b1; irq_lvl = 3'd7; irq_vec = 8'h33;
    end
    @(posedge clk); #1;
    idle_inputs();
    expect_busy(2, with_irq ? "R10 return wins" : "R9 return busy/done");
  endtask

  task automatic do_quiet(logic [15:0] psr, bit bnd, logic [2:0] lvl, string tag);
    @(posedge clk); #1;
    psr_in = psr; sp_in = 16'h0080; pc_in = 16'h1234;
    at_boundary = bnd; irq_req = 1'b1; irq_lvl = lvl; irq_vec = 8'h05;
    @(posedge clk); #1;
    idle_inputs();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(busy == 1'b0, tag, 16'(busy), 16'h0);
    end
    check(exp_q.size() == 0, tag, 16'(exp_q.size()), 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0;
    idle_inputs();
    psr_in = 16'h0; pc_in = 16'h0; sp_in = 16'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check(!busy && !done && !priv_fault, "R11 status low", {13'h0, busy, done, priv_fault}, 16'h0);
    check(!mem_req && !pc_we && !psr_we && !sp_we, "R11 enables low",
          {12'h0, mem_req, pc_we, psr_we, sp_we}, 16'h0);

    // R2 higher level accepted
    do_irq(16'h8201, 16'h3010, 16'h0090, 3'd4, 8'h20, 16'h0400);
    // R2 equal level accepted, R6 clears user flag and condition codes
    do_irq(16'h8504, 16'h3011, 16'h0070, 3'd5, 8'h7F, 16'h0555);
    // stack wrap through 0x0000
    do_irq(16'h0002, 16'h4000, 16'h0001, 3'd1, 8'h00, 16'h0600);
    // R1 outranked request refused
    do_quiet(16'h0600, 1'b1, 3'd3, "R1 reject");
    // R3 no boundary
    do_quiet(16'h0000, 1'b0, 3'd7, "R3 off boundary");
    // R7 privileged return
    do_rti(16'h00A0, 16'h3020, 16'h8102, 1'b0);
    // R10 return and interrupt together
    do_rti(16'h00B0, 16'h3030, 16'h0004, 1'b1);

    // R8 return in user mode
    @(posedge clk); #1;
    psr_in = 16'h8000; sp_in = 16'h00C0; rti_req = 1'b1;
    @(negedge clk);
    check(priv_fault == 1'b1, "R8 fault raised", 16'(priv_fault), 16'h1);
    @(posedge clk); #1;
    idle_inputs();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(busy == 1'b0 && priv_fault == 1'b0, "R8 no sequence", {14'h0, busy, priv_fault}, 16'h0);
    end
    check(exp_q.size() == 0, "R8 no events", 16'(exp_q.size()), 16'h0);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule